// File: doc/BRIEF.md
# Six-Source Maskable Interrupt Aggregator with Re-Pulse

This block gathers six internal event sources onto one active-high interrupt line. Each source has a sticky pending flag, which a one-cycle event pulse sets and software clears by writing a 1 to the matching bit of a clear word. Each flag also has a mask bit. The line is high while any pending flag whose mask bit is set remains pending.

One source (index 5 by default) records that a reset took place. Its pending flag comes up set after every reset, so a short glitch on the reset input can still be seen afterwards. The cycle after a clear strobe, the line is driven low for one cycle, which matches the width of the strobe. If an unmasked flag is still pending, the line rises again on the following cycle. This gives an edge-sensitive host a fresh rising edge for the interrupt that remains, while a level-sensitive host sees an ordinary level.

The line is driven by a three-state machine:
- LINE_IDLE: the line is low because nothing unmasked is pending.
- LINE_ACTIVE: the line is high.
- LINE_BREAK: the forced low cycle after a clear strobe.

Transitions:
- to_break: any state goes to LINE_BREAK on a clear strobe.
- to_active: any state goes to LINE_ACTIVE when there is no strobe and the next pending-and-mask is non-zero.
- to_idle: any state goes to LINE_IDLE when there is no strobe and nothing unmasked will be pending.

Top module: `irq_agg`

## Requirements
- R1: After reset, the pending flags read 6'b100000 (only the reset-source flag, bit 5, is set), the mask reads 6'b000000 and `irq_o` is 0. This holds for a reset asserted in the middle of operation too.
- R2: An `evt_i[k]`=1 in one cycle makes `pend_o[k]` read 1 after the next rising edge. The flag stays 1 until it is cleared.
- R3: A cycle with `clr_wr_i`=1 clears each pending flag k with `clr_data_i[k]`=1. Flags with `clr_data_i[k]`=0 are left unchanged, so a clear word of all zeros changes no flag.
- R4: When `evt_i[k]` and a clear of bit k arrive in the same cycle, the flag is 1 after the edge (set wins).
- R5: A cycle with `mask_wr_i`=1 loads all six bits of `mask_data_i` into the mask. A 1 enables the source. `mask_o` shows the mask after the edge.
- R6: Without a clear strobe, after each rising edge `irq_o` equals the OR of (`pend_o` AND `mask_o`) as they stand after that edge.
- R7: A pending flag whose mask bit is 0 never drives `irq_o` high.
- R8: After the edge that samples `clr_wr_i`=1, `irq_o` is 0 for exactly one cycle. It then returns to 1 if an unmasked flag is still pending, and otherwise stays 0.
- R9: Back-to-back clear strobes keep `irq_o` low for every cycle that follows a strobe edge. The line rises one cycle after the last strobe if an unmasked flag remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | One-cycle event pulses, one per source |
| clr_wr_i | input | 1 | Clear-word write strobe |
| clr_data_i | input | 6 | Clear word: 1 clears the matching flag |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_data_i | input | 6 | New mask value, 1 enables a source |
| pend_o | output | 6 | Pending flags |
| mask_o | output | 6 | Mask bits |
| irq_o | output | 1 | Combined active-high interrupt line |

## Verification
The assertions check three things on every cycle:
- each flag's set and hold rules, and set-over-clear priority;
- that the mask takes the written word;
- that the line is never high without an unmasked pending flag, follows pending-and-mask after every edge with no strobe, and is low after every strobe edge.

The bench's scenarios are needed for the rest:
- the reset value of the reset-source flag, including after a mid-run reset;
- a clear word of zeros that changes no flag;
- the re-pulse shape as the host sees it: a low cycle followed by a rising edge only when something unmasked remains;
- the stretched low gap under back-to-back strobes.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int SRC_COUNT_DEF = 6;
    localparam int RST_SRC_DEF   = 5;

    typedef enum logic [1:0] {
        LINE_IDLE   = 2'd0,
        LINE_ACTIVE = 2'd1,
        LINE_BREAK  = 2'd2
    } line_state_e;
endpackage

// File: rtl/irq_agg_pend_bank.sv
module irq_agg_pend_bank #(
    parameter int N_SRC   = 6,
    parameter int RST_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             clr_wr_i,
    input  logic [N_SRC-1:0] clr_data_i,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] pend_next_o
);
    logic [N_SRC-1:0] clr_hit;
    assign clr_hit = clr_wr_i ? clr_data_i : '0;

    for (genvar k = 0; k < N_SRC; k++) begin : g_flag
        localparam logic RST_VAL = (k == RST_SRC);
        logic flag_q;
        logic flag_d;

        // Set has priority over clear
        assign flag_d = evt_i[k] | (flag_q & ~clr_hit[k]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= RST_VAL;
            else        flag_q <= flag_d;
        end

        assign pend_o[k]      = flag_q;
        assign pend_next_o[k] = flag_d;

        a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[k] |=> flag_q);
        a_r3_hold_unless_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && !(clr_wr_i && clr_data_i[k])) |=> flag_q);
        a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr_i && clr_data_i[k] && !evt_i[k]) |=> !flag_q);
    end
endmodule

// File: rtl/irq_agg_mask_reg.sv
module irq_agg_mask_reg #(
    parameter int N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr_i,
    input  logic [N_SRC-1:0] mask_data_i,
    output logic [N_SRC-1:0] mask_o,
    output logic [N_SRC-1:0] mask_next_o
);
    logic [N_SRC-1:0] mask_q;

    assign mask_next_o = mask_wr_i ? mask_data_i : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_next_o;
    end

    assign mask_o = mask_q;

    a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> (mask_q == $past(mask_data_i)));
endmodule

// File: rtl/irq_agg_line_fsm.sv
module irq_agg_line_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_wr_i,
    input  logic any_next_i,
    output logic irq_o
);
    line_state_e state_q;
    line_state_e state_d;

    // Next-state selection: to_break, to_active, to_idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE, LINE_ACTIVE, LINE_BREAK: begin
                if (clr_wr_i)        state_d = LINE_BREAK;
                else if (any_next_i) state_d = LINE_ACTIVE;
                else                 state_d = LINE_IDLE;
            end
            default: state_d = LINE_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            LINE_ACTIVE: irq_o = 1'b1;
            LINE_IDLE:   irq_o = 1'b0;
            LINE_BREAK:  irq_o = 1'b0;
            default:     irq_o = 1'b0;
        endcase
    end

    a_r8_low_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> !irq_o);
    a_r9_break_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LINE_BREAK && !clr_wr_i) |=> (state_q != LINE_BREAK));
endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int N_SRC   = SRC_COUNT_DEF,
    parameter int RST_SRC = RST_SRC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             clr_wr_i,
    input  logic [N_SRC-1:0] clr_data_i,
    input  logic             mask_wr_i,
    input  logic [N_SRC-1:0] mask_data_i,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] mask_o,
    output logic             irq_o
);
    logic [N_SRC-1:0] pend_next;
    logic [N_SRC-1:0] mask_next;
    logic             any_next;

    irq_agg_pend_bank #(.N_SRC(N_SRC), .RST_SRC(RST_SRC)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .clr_wr_i    (clr_wr_i),
        .clr_data_i  (clr_data_i),
        .pend_o      (pend_o),
        .pend_next_o (pend_next)
    );

    irq_agg_mask_reg #(.N_SRC(N_SRC)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_wr_i   (mask_wr_i),
        .mask_data_i (mask_data_i),
        .mask_o      (mask_o),
        .mask_next_o (mask_next)
    );

    assign any_next = |(pend_next & mask_next);

    irq_agg_line_fsm u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_wr_i   (clr_wr_i),
        .any_next_i (any_next),
        .irq_o      (irq_o)
    );

    a_r7_no_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(pend_o & mask_o)));
    a_r6_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr_i |=> (irq_o == (|(pend_o & mask_o))));
endmodule

// File: tb/irq_agg_tb.sv
module irq_agg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt_i = '0;
    logic       clr_wr_i = 1'b0;
    logic [5:0] clr_data_i = '0;
    logic       mask_wr_i = 1'b0;
    logic [5:0] mask_data_i = '0;
    logic [5:0] pend_o;
    logic [5:0] mask_o;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_wr_i(clr_wr_i),
        .clr_data_i(clr_data_i), .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i),
        .pend_o(pend_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    // Vector layout: evt[32:27] cw[26] cd[25:20] mw[19] md[18:13] pend[12:7] mask[6:1] irq[0]
    localparam int NV = 18;
    localparam logic [32:0] VEC [NV] = '{
        {6'b000000,1'b0,6'b000000,1'b1,6'b111111, 6'b100000,6'b111111,1'b1}, // R5 R6
        {6'b000000,1'b0,6'b000000,1'b0,6'b000000, 6'b100000,6'b111111,1'b1}, // R6
        {6'b000001,1'b0,6'b000000,1'b0,6'b000000, 6'b100001,6'b111111,1'b1}, // R2
        {6'b000000,1'b1,6'b100000,1'b0,6'b000000, 6'b000001,6'b111111,1'b0}, // R3 R8 break
        {6'b000000,1'b0,6'b000000,1'b0,6'b000000, 6'b000001,6'b111111,1'b1}, // R8 re-pulse
        {6'b000000,1'b1,6'b000001,1'b0,6'b000000, 6'b000000,6'b111111,1'b0}, // R3
        {6'b000000,1'b0,6'b000000,1'b0,6'b000000, 6'b000000,6'b111111,1'b0}, // R8 stays low
        {6'b000000,1'b0,6'b000000,1'b1,6'b000010, 6'b000000,6'b000010,1'b0}, // R5
        {6'b000100,1'b0,6'b000000,1'b0,6'b000000, 6'b000100,6'b000010,1'b0}, // R7
        {6'b000010,1'b0,6'b000000,1'b0,6'b000000, 6'b000110,6'b000010,1'b1}, // R2 R6
        {6'b000010,1'b1,6'b000010,1'b0,6'b000000, 6'b000110,6'b000010,1'b0}, // R4 R8
        {6'b000000,1'b0,6'b000000,1'b0,6'b000000, 6'b000110,6'b000010,1'b1}, // R8
        {6'b000000,1'b1,6'b000000,1'b0,6'b000000, 6'b000110,6'b000010,1'b0}, // R3 zero word
        {6'b000000,1'b0,6'b000000,1'b0,6'b000000, 6'b000110,6'b000010,1'b1}, // R8
        {6'b000000,1'b1,6'b000010,1'b0,6'b000000, 6'b000100,6'b000010,1'b0}, // R3
        {6'b000000,1'b0,6'b000000,1'b0,6'b000000, 6'b000100,6'b000010,1'b0}, // R7 R8
        {6'b000000,1'b0,6'b000000,1'b1,6'b000100, 6'b000100,6'b000100,1'b1}, // R5 R6
        {6'b000000,1'b1,6'b000100,1'b0,6'b000000, 6'b000000,6'b000100,1'b0}  // R3 R8
    };

    task automatic chk(input string what, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with inputs idle
    task automatic step(input logic [5:0] e, input logic cw, input logic [5:0] cd,
                        input logic mw, input logic [5:0] md);
        evt_i = e; clr_wr_i = cw; clr_data_i = cd; mask_wr_i = mw; mask_data_i = md;
        @(negedge clk);
        evt_i = '0; clr_wr_i = 1'b0; clr_data_i = '0; mask_wr_i = 1'b0; mask_data_i = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset pend", pend_o, 6'b100000);
        chk("R1 reset mask", mask_o, 6'b000000);
        chk("R1 reset irq", {5'b0, irq_o}, 6'b000000);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 (tags per row above)
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][32:27], VEC[i][26], VEC[i][25:20], VEC[i][19], VEC[i][18:13]);
            chk($sformatf("table vec %0d pend", i), pend_o, VEC[i][12:7]);
            chk($sformatf("table vec %0d mask", i), mask_o, VEC[i][6:1]);
            chk($sformatf("table vec %0d irq", i), {5'b0, irq_o}, {5'b0, VEC[i][0]});
        end

        // R9: back-to-back clear strobes
        step(6'b000011, 1'b0, 6'b0, 1'b1, 6'b111111);
        chk("R9 setup irq", {5'b0, irq_o}, 6'b000001);
        step(6'b0, 1'b1, 6'b000001, 1'b0, 6'b0);
        chk("R9 first strobe irq", {5'b0, irq_o}, 6'b000000);
        step(6'b0, 1'b1, 6'b000000, 1'b0, 6'b0);
        chk("R9 second strobe irq", {5'b0, irq_o}, 6'b000000);
        chk("R9 pend after strobes", pend_o, 6'b000010);
        step(6'b0, 1'b0, 6'b0, 1'b0, 6'b0);
        chk("R9 line back up", {5'b0, irq_o}, 6'b000001);

        // R1: reset in the middle of operation
        do_reset();
        chk("R1 mid-run pend", pend_o, 6'b100000);
        chk("R1 mid-run mask", mask_o, 6'b000000);
        chk("R1 mid-run irq", {5'b0, irq_o}, 6'b000000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule